// File: doc/BRIEF.md
# GEMM tile command sequencer

This block drives a tiled matrix multiply C[M×N] = A[M×K]·B[K×N] without any software loop. It splits the job into output tiles of at most TILE_MAX×TILE_MAX elements. For each output tile it walks the reduction dimension and emits a fixed series of commands on one command port. The memory mover and the matrix engine behind that port carry the commands out.

A job is set up on the configuration inputs and launched with a one-cycle `start`. The configuration is the three matrix extents, the three tile sizes, and a base address and a row stride (in elements) for each matrix.

For every output tile, the partial-sum tile is fetched into scratchpad partition 1 once. Each reduction step then fetches an activation tile into partition 0 and a weight tile into partition 1, followed by a blocking multiply-accumulate. The output tile is written back once, after its last reduction step. Activations and weights sit in different partitions so that fetches can run alongside compute. Each command waits for its `cmd_done` pulse before the next one is offered.

Top module: `gemm_tile_seq`

## Requirements
- R1: Each tile size is taken at `start`. A value of 0 is used as 1, and a value above TILE_MAX (32) is used as 32.
- R2: Output tiles are visited with the row index outermost and the column index next. For each output tile the commands are: load-C, then (load-A, load-B, mac) once per reduction step with the reduction origin increasing, then store-C.
- R3: The tile counts are ceil(M/TM), ceil(N/TN) and ceil(K/TK). The rows and columns of an edge tile are clipped to the extent that remains, so no tile reaches past M, N or K.
- R4: `cmd_kind` is encoded as load-C=0, load-A=1, load-B=2, mac=3 and store-C=4. `cmd_part` is 0 for load-A and 1 for every other kind.
- R5: `cmd_addr` is base + row·stride + column. Load-A uses A at (i·TM, k·TK) with rows=TM' and cols=TK'. Load-B uses B at (k·TK, j·TN) with rows=TK' and cols=TN'. Load-C, mac and store-C use C at (i·TM, j·TN) with rows=TM' and cols=TN'. A primed size is the clipped one.
- R6: While `cmd_valid` is high and `cmd_ready` is low, every command field holds its value. A command is taken on a cycle where both are high.
- R7: After a command is taken, `cmd_valid` stays low until `cmd_done` has been seen. The next command appears in the cycle after that.
- R8: `busy` is high from the cycle after an accepted `start` until the final store-C completes. In the following cycle `busy` is low and `done` is high for exactly one cycle.
- R9: If M, N or K is 0 at `start`, no command is issued, `busy` stays low, and `done` pulses in the next cycle.
- R10: A `start` while `busy` is high is ignored. The running job continues with its own configuration.
- R11: After reset, `busy`, `done` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | launch pulse; configuration is sampled on it |
| cfg_m | input | DIM_W | rows of A and C |
| cfg_n | input | DIM_W | columns of B and C |
| cfg_k | input | DIM_W | reduction extent |
| cfg_tm | input | CFG_TW | requested output-tile rows |
| cfg_tn | input | CFG_TW | requested output-tile columns |
| cfg_tk | input | CFG_TW | requested reduction slice |
| base_a | input | ADDR_W | element address of A[0][0] |
| base_b | input | ADDR_W | element address of B[0][0] |
| base_c | input | ADDR_W | element address of C[0][0] |
| stride_a | input | DIM_W | row stride of A in elements |
| stride_b | input | DIM_W | row stride of B in elements |
| stride_c | input | DIM_W | row stride of C in elements |
| cmd_valid | output | 1 | command offered |
| cmd_ready | input | 1 | command taken when high with valid |
| cmd_kind | output | 3 | command code (R4) |
| cmd_addr | output | ADDR_W | tile origin address |
| cmd_rows | output | TILE_W | tile rows |
| cmd_cols | output | TILE_W | tile columns |
| cmd_part | output | 1 | scratchpad partition |
| cmd_done | input | 1 | completion pulse of the taken command |
| busy | output | 1 | job in progress |
| done | output | 1 | one-cycle job-finished pulse |

## Verification
The assertions assume that `cmd_done` arrives only for a command already taken, and that the configuration inputs matter only in the cycle of `start`. The bench acts as the responder. It raises `cmd_done` only after each acceptance, with a varying delay, and holds `cmd_ready` low for a few cycles on some commands. It moves the configuration inputs only around `start` pulses, including one extra pulse sent during a running job.

// File: rtl/gts_pkg.sv
package gts_pkg;

  typedef enum logic [2:0] {
    PH_LDC = 3'd0,
    PH_LDA = 3'd1,
    PH_LDB = 3'd2,
    PH_MMA = 3'd3,
    PH_STC = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    K_LDC = 3'd0,
    K_LDA = 3'd1,
    K_LDB = 3'd2,
    K_MMA = 3'd3,
    K_STC = 3'd4
  } cmd_kind_e;

  localparam logic PART_ACT = 1'b0;
  localparam logic PART_WC  = 1'b1;

endpackage

// File: rtl/gts_cfg_latch.sv
module gts_cfg_latch #(
  parameter int DIM_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int CFG_TW   = 8,
  parameter int TILE_MAX = 32,
  parameter int TILE_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIM_W-1:0]  in_m,
  input  logic [DIM_W-1:0]  in_n,
  input  logic [DIM_W-1:0]  in_k,
  input  logic [CFG_TW-1:0] in_tm,
  input  logic [CFG_TW-1:0] in_tn,
  input  logic [CFG_TW-1:0] in_tk,
  input  logic [ADDR_W-1:0] in_ba,
  input  logic [ADDR_W-1:0] in_bb,
  input  logic [ADDR_W-1:0] in_bc,
  input  logic [DIM_W-1:0]  in_sa,
  input  logic [DIM_W-1:0]  in_sb,
  input  logic [DIM_W-1:0]  in_sc,
  output logic              in_empty,
  output logic [DIM_W-1:0]  dim_m,
  output logic [DIM_W-1:0]  dim_n,
  output logic [DIM_W-1:0]  dim_k,
  output logic [TILE_W-1:0] t_m,
  output logic [TILE_W-1:0] t_n,
  output logic [TILE_W-1:0] t_k,
  output logic [ADDR_W-1:0] ba,
  output logic [ADDR_W-1:0] bb,
  output logic [ADDR_W-1:0] bc,
  output logic [DIM_W-1:0]  sa,
  output logic [DIM_W-1:0]  sb,
  output logic [DIM_W-1:0]  sc
);

  // Zero means one, anything past the array edge means the edge.
  function automatic logic [TILE_W-1:0] clamp_tile(input logic [CFG_TW-1:0] v);
    if (v == '0) return TILE_W'(1);
    if (v > CFG_TW'(TILE_MAX)) return TILE_W'(TILE_MAX);
    return TILE_W'(v);
  endfunction

  assign in_empty = (in_m == '0) || (in_n == '0) || (in_k == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_m <= '0; dim_n <= '0; dim_k <= '0;
      t_m   <= '0; t_n   <= '0; t_k   <= '0;
      ba    <= '0; bb    <= '0; bc    <= '0;
      sa    <= '0; sb    <= '0; sc    <= '0;
    end else if (load) begin
      dim_m <= in_m; dim_n <= in_n; dim_k <= in_k;
      t_m   <= clamp_tile(in_tm);
      t_n   <= clamp_tile(in_tn);
      t_k   <= clamp_tile(in_tk);
      ba    <= in_ba; bb <= in_bb; bc <= in_bc;
      sa    <= in_sa; sb <= in_sb; sc <= in_sc;
    end
  end

endmodule

// File: rtl/gts_tile_walker.sv
module gts_tile_walker #(
  parameter int DIM_W    = 16,
  parameter int TILE_MAX = 32,
  parameter int TILE_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              clear,
  input  logic              adv_k,
  input  logic              adv_out,
  input  logic [DIM_W-1:0]  dim_m,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  dim_k,
  input  logic [TILE_W-1:0] t_m,
  input  logic [TILE_W-1:0] t_n,
  input  logic [TILE_W-1:0] t_k,
  output logic [DIM_W-1:0]  row0,
  output logic [DIM_W-1:0]  col0,
  output logic [DIM_W-1:0]  red0,
  output logic [TILE_W-1:0] rows_c,
  output logic [TILE_W-1:0] cols_c,
  output logic [TILE_W-1:0] red_c,
  output logic              last_k,
  output logic              last_out
);

  localparam int EW = DIM_W + 1;

  // Size of a tile starting at org, cut to what is left of the extent.
  function automatic logic [TILE_W-1:0] clip_ext(input logic [DIM_W-1:0] dim,
                                                 input logic [DIM_W-1:0] org,
                                                 input logic [TILE_W-1:0] t);
    logic [DIM_W-1:0] left;
    left = dim - org;
    if (left < DIM_W'(t)) return TILE_W'(left);
    return t;
  endfunction

  // True when the tile at org is the final one along the extent.
  function automatic logic reaches_end(input logic [DIM_W-1:0] dim,
                                       input logic [DIM_W-1:0] org,
                                       input logic [TILE_W-1:0] t);
    return ({1'b0, org} + EW'(t)) >= {1'b0, dim};
  endfunction

  logic last_col, last_row;

  assign rows_c   = clip_ext(dim_m, row0, t_m);
  assign cols_c   = clip_ext(dim_n, col0, t_n);
  assign red_c    = clip_ext(dim_k, red0, t_k);
  assign last_k   = reaches_end(dim_k, red0, t_k);
  assign last_col = reaches_end(dim_n, col0, t_n);
  assign last_row = reaches_end(dim_m, row0, t_m);
  assign last_out = last_col && last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row0 <= '0; col0 <= '0; red0 <= '0;
    end else if (clear) begin
      row0 <= '0; col0 <= '0; red0 <= '0;
    end else if (adv_k) begin
      red0 <= red0 + DIM_W'(t_k);
    end else if (adv_out) begin
      red0 <= '0;
      if (last_col) begin
        col0 <= '0;
        row0 <= row0 + DIM_W'(t_m);
      end else begin
        col0 <= col0 + DIM_W'(t_n);
      end
    end
  end

  AST_TILE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rows_c != '0 && rows_c <= TILE_W'(TILE_MAX) &&
                cols_c != '0 && cols_c <= TILE_W'(TILE_MAX) &&
                red_c  != '0 && red_c  <= TILE_W'(TILE_MAX)));  // R1

  AST_CLIP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (row0 < dim_m && col0 < dim_n && red0 < dim_k));  // R3

endmodule

// File: rtl/gts_cmd_fsm.sv
module gts_cmd_fsm
  import gts_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   job_empty,
  input  logic   cmd_ready,
  input  logic   cmd_done,
  input  logic   last_k,
  input  logic   last_out,
  output logic   cmd_valid,
  output phase_e phase,
  output logic   load_cfg,
  output logic   walk_clear,
  output logic   adv_k,
  output logic   adv_out,
  output logic   busy,
  output logic   done,
  output logic   cmd_fire,
  output logic   step_done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e    st_q, st_d;
  phase_e ph_q, ph_d;
  logic   done_q, done_d;

  assign cmd_valid = (st_q == ST_ISSUE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign phase     = ph_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign step_done = (st_q == ST_WAIT) && cmd_done;

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    done_d     = 1'b0;
    load_cfg   = 1'b0;
    walk_clear = 1'b0;
    adv_k      = 1'b0;
    adv_out    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load_cfg = 1'b1;
          if (job_empty) begin
            done_d = 1'b1;
          end else begin
            st_d       = ST_ISSUE;
            ph_d       = PH_LDC;
            walk_clear = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (cmd_fire) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (step_done) begin
          st_d = ST_ISSUE;
          case (ph_q)
            PH_LDC: ph_d = PH_LDA;
            PH_LDA: ph_d = PH_LDB;
            PH_LDB: ph_d = PH_MMA;
            PH_MMA: begin
              if (last_k) begin
                ph_d = PH_STC;
              end else begin
                adv_k = 1'b1;
                ph_d  = PH_LDA;
              end
            end
            PH_STC: begin
              if (last_out) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
              end else begin
                adv_out = 1'b1;
                ph_d    = PH_LDC;
              end
            end
            default: ph_d = PH_LDC;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_LDC;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_valid);  // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R8

endmodule

// File: rtl/gts_cmd_fmt.sv
module gts_cmd_fmt
  import gts_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TILE_W = 6
) (
  input  phase_e            phase,
  input  logic [DIM_W-1:0]  row0,
  input  logic [DIM_W-1:0]  col0,
  input  logic [DIM_W-1:0]  red0,
  input  logic [TILE_W-1:0] rows_c,
  input  logic [TILE_W-1:0] cols_c,
  input  logic [TILE_W-1:0] red_c,
  input  logic [ADDR_W-1:0] ba,
  input  logic [ADDR_W-1:0] bb,
  input  logic [ADDR_W-1:0] bc,
  input  logic [DIM_W-1:0]  sa,
  input  logic [DIM_W-1:0]  sb,
  input  logic [DIM_W-1:0]  sc,
  output cmd_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [TILE_W-1:0] rows,
  output logic [TILE_W-1:0] cols,
  output logic              part
);

  // Element address of (row, col) in a row-major matrix.
  function automatic logic [ADDR_W-1:0] tile_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [DIM_W-1:0]  row,
                                                  input logic [DIM_W-1:0]  stride,
                                                  input logic [DIM_W-1:0]  col);
    return base + ADDR_W'(row) * ADDR_W'(stride) + ADDR_W'(col);
  endfunction

  logic [ADDR_W-1:0] addr_a, addr_b, addr_c;

  assign addr_a = tile_addr(ba, row0, sa, red0);
  assign addr_b = tile_addr(bb, red0, sb, col0);
  assign addr_c = tile_addr(bc, row0, sc, col0);

  always_comb begin
    kind = K_LDC;
    addr = addr_c;
    rows = rows_c;
    cols = cols_c;
    part = PART_WC;
    case (phase)
      PH_LDA: begin
        kind = K_LDA; addr = addr_a; cols = red_c; part = PART_ACT;
      end
      PH_LDB: begin
        kind = K_LDB; addr = addr_b; rows = red_c;
      end
      PH_MMA:  kind = K_MMA;
      PH_STC:  kind = K_STC;
      default: kind = K_LDC;
    endcase
  end

endmodule

// File: rtl/gemm_tile_seq.sv
module gemm_tile_seq
  import gts_pkg::*;
#(
  parameter int DIM_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int CFG_TW   = 8,
  parameter int TILE_MAX = 32,
  localparam int TILE_W  = $clog2(TILE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_m,
  input  logic [DIM_W-1:0]  cfg_n,
  input  logic [DIM_W-1:0]  cfg_k,
  input  logic [CFG_TW-1:0] cfg_tm,
  input  logic [CFG_TW-1:0] cfg_tn,
  input  logic [CFG_TW-1:0] cfg_tk,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [ADDR_W-1:0] base_c,
  input  logic [DIM_W-1:0]  stride_a,
  input  logic [DIM_W-1:0]  stride_b,
  input  logic [DIM_W-1:0]  stride_c,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TILE_W-1:0] cmd_rows,
  output logic [TILE_W-1:0] cmd_cols,
  output logic              cmd_part,
  input  logic              cmd_done,
  output logic              busy,
  output logic              done
);

  logic              job_empty, load_cfg, walk_clear, adv_k, adv_out;
  logic              last_k, last_out, cmd_fire, step_done;
  phase_e            phase;
  cmd_kind_e         kind;
  logic [DIM_W-1:0]  dim_m, dim_n, dim_k, sa, sb, sc;
  logic [DIM_W-1:0]  row0, col0, red0;
  logic [TILE_W-1:0] t_m, t_n, t_k, rows_c, cols_c, red_c;
  logic [ADDR_W-1:0] ba, bb, bc;

  gts_cfg_latch #(
    .DIM_W(DIM_W), .ADDR_W(ADDR_W), .CFG_TW(CFG_TW),
    .TILE_MAX(TILE_MAX), .TILE_W(TILE_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load_cfg),
    .in_m(cfg_m), .in_n(cfg_n), .in_k(cfg_k),
    .in_tm(cfg_tm), .in_tn(cfg_tn), .in_tk(cfg_tk),
    .in_ba(base_a), .in_bb(base_b), .in_bc(base_c),
    .in_sa(stride_a), .in_sb(stride_b), .in_sc(stride_c),
    .in_empty(job_empty),
    .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
    .t_m(t_m), .t_n(t_n), .t_k(t_k),
    .ba(ba), .bb(bb), .bc(bc), .sa(sa), .sb(sb), .sc(sc)
  );

  gts_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .job_empty(job_empty),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .last_k(last_k), .last_out(last_out),
    .cmd_valid(cmd_valid), .phase(phase), .load_cfg(load_cfg),
    .walk_clear(walk_clear), .adv_k(adv_k), .adv_out(adv_out),
    .busy(busy), .done(done), .cmd_fire(cmd_fire), .step_done(step_done)
  );

  gts_tile_walker #(
    .DIM_W(DIM_W), .TILE_MAX(TILE_MAX), .TILE_W(TILE_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .active(busy), .clear(walk_clear),
    .adv_k(adv_k), .adv_out(adv_out),
    .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
    .t_m(t_m), .t_n(t_n), .t_k(t_k),
    .row0(row0), .col0(col0), .red0(red0),
    .rows_c(rows_c), .cols_c(cols_c), .red_c(red_c),
    .last_k(last_k), .last_out(last_out)
  );

  gts_cmd_fmt #(
    .DIM_W(DIM_W), .ADDR_W(ADDR_W), .TILE_W(TILE_W)
  ) u_fmt (
    .phase(phase), .row0(row0), .col0(col0), .red0(red0),
    .rows_c(rows_c), .cols_c(cols_c), .red_c(red_c),
    .ba(ba), .bb(bb), .bc(bc), .sa(sa), .sb(sb), .sc(sc),
    .kind(kind), .addr(cmd_addr), .rows(cmd_rows), .cols(cmd_cols),
    .part(cmd_part)
  );

  assign cmd_kind = kind;

  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) &&
                                   $stable(cmd_rows) && $stable(cmd_cols) && $stable(cmd_part)));  // R6

  AST_FIRST_LDC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd_kind == K_LDC));  // R2

  AST_STORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == K_STC) |-> last_k);  // R2

  AST_PART_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == K_LDA) |-> (cmd_part == PART_ACT));  // R4

endmodule

// File: tb/gemm_tile_seq_test.sv
module gemm_tile_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_m = '0, cfg_n = '0, cfg_k = '0;
  logic [7:0]  cfg_tm = '0, cfg_tn = '0, cfg_tk = '0;
  logic [31:0] base_a = '0, base_b = '0, base_c = '0;
  logic [15:0] stride_a = '0, stride_b = '0, stride_c = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [2:0]  cmd_kind;
  logic [31:0] cmd_addr;
  logic [5:0]  cmd_rows, cmd_cols;
  logic        cmd_part;
  logic        cmd_done = 1'b0;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;
  int cmd_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gemm_tile_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_k(cfg_k),
    .cfg_tm(cfg_tm), .cfg_tn(cfg_tn), .cfg_tk(cfg_tk),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .stride_a(stride_a), .stride_b(stride_b), .stride_c(stride_c),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_rows(cmd_rows), .cmd_cols(cmd_cols),
    .cmd_part(cmd_part), .cmd_done(cmd_done), .busy(busy), .done(done)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int eff_tile(input int v);
    if (v < 1) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic int span(input int extent, input int org, input int t);
    return (extent - org < t) ? extent - org : t;
  endfunction

  function automatic logic [63:0] pack(input int kd, input logic [31:0] ad,
                                       input int rw, input int cl, input int pt);
    return {12'h0, kd[2:0], pt[0], rw[7:0], cl[7:0], ad};
  endfunction

  function automatic logic [63:0] port_cmd();
    return {12'h0, cmd_kind, cmd_part, 2'b00, cmd_rows, 2'b00, cmd_cols, cmd_addr};
  endfunction

  // Serve one command: compare it, optionally stall, accept, then complete.
  task automatic serve(input string tag, input logic [63:0] exp, input int mode);
    int w = 0;
    int stall = (mode == 1 && (cmd_idx % 3) == 0) ? 2 : 0;
    int dly   = (mode == 1) ? (cmd_idx % 4) : 0;
    logic [63:0] held;
    while (!cmd_valid && w < 200) begin
      @(negedge clk); w++;
    end
    check_eq({tag, " R7 valid"}, 64'(cmd_valid), 64'd1);
    check_eq({tag, " R2 R3 R4 R5 cmd"}, port_cmd(), exp);
    held = port_cmd();
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check_eq({tag, " R6 held"}, {port_cmd()[63:1], cmd_valid}, {held[63:1], 1'b1});
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    check_eq({tag, " R7 quiet after take"}, 64'(cmd_valid), 64'd0);
    repeat (dly) @(negedge clk);
    if (dly > 0) check_eq({tag, " R7 quiet while waiting"}, 64'(cmd_valid), 64'd0);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    cmd_idx++;
  endtask

  task automatic run_job(input string tag, input int m, input int n, input int k,
                         input int tm, input int tn, input int tk,
                         input int mode, input bit poke);
    int etm = eff_tile(tm);
    int etn = eff_tile(tn);
    int etk = eff_tile(tk);
    logic [31:0] ba = 32'h1000_0000, bb = 32'h2000_4000, bc = 32'h3000_8000;
    int sa = k + 3, sb = n + 1, sc = n + 5;
    @(negedge clk);
    cfg_m = 16'(m); cfg_n = 16'(n); cfg_k = 16'(k);
    cfg_tm = 8'(tm); cfg_tn = 8'(tn); cfg_tk = 8'(tk);
    base_a = ba; base_b = bb; base_c = bc;
    stride_a = 16'(sa); stride_b = 16'(sb); stride_c = 16'(sc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_eq({tag, " R8 busy after start"}, 64'(busy), 64'd1);
    if (poke) begin
      // R10: a second launch with other settings must change nothing
      cfg_m = 16'd5; cfg_n = 16'd5; cfg_k = 16'd5; cfg_tm = 8'd1;
      base_c = 32'hDEAD_0000; stride_c = 16'd99;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int r = 0; r < m; r += etm) begin
      for (int c = 0; c < n; c += etn) begin
        int rr = span(m, r, etm);
        int cc = span(n, c, etn);
        logic [31:0] ac = bc + 32'(r * sc + c);
        serve(tag, pack(0, ac, rr, cc, 1), mode);
        for (int q = 0; q < k; q += etk) begin
          int kk = span(k, q, etk);
          serve(tag, pack(1, ba + 32'(r * sa + q), rr, kk, 0), mode);
          serve(tag, pack(2, bb + 32'(q * sb + c), kk, cc, 1), mode);
          serve(tag, pack(3, ac, rr, cc, 1), mode);
        end
        serve(tag, pack(4, ac, rr, cc, 1), mode);
      end
    end
    check_eq({tag, " R8 done pulse"}, {62'd0, busy, done}, 64'b01);
    check_eq({tag, " R2 no extra command"}, 64'(cmd_valid), 64'd0);
    @(negedge clk);
    check_eq({tag, " R8 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check_eq("R11 reset outputs", {61'd0, busy, done, cmd_valid}, 64'd0);
  endtask

  task automatic t_empty();
    @(negedge clk);
    cfg_m = 16'd8; cfg_n = 16'd8; cfg_k = 16'd0;
    cfg_tm = 8'd4; cfg_tn = 8'd4; cfg_tk = 8'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_eq("R9 empty job: done, no busy, no cmd", {61'd0, busy, done, cmd_valid}, 64'b010);
    @(negedge clk);
    check_eq("R9 empty job stays quiet", {61'd0, busy, done, cmd_valid}, 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_job("exact 64x64x64 T32", 64, 64, 64, 32, 32, 32, 0, 1'b0);
    run_job("ragged R3 40x20x50", 40, 20, 50, 16, 8, 24, 0, 1'b0);
    run_job("R1 clamp tiles", 33, 2, 33, 40, 0, 255, 0, 1'b0);
    run_job("R6 R10 stall and relaunch", 10, 12, 9, 4, 8, 5, 1, 1'b1);
    t_empty();
    run_job("single element", 1, 1, 1, 32, 32, 32, 1, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule